// File: doc/BRIEF.md
# Three-Channel Register-Mapped Timer Counter

This peripheral holds three identical up-counting timer channels behind a small 32-bit register bus. Each channel divides a shared tick input through its own power-of-two prescaler. It then counts either freely, wrapping at the top of its counter width, or in interval mode, where it returns to zero after reaching a programmed limit. Each wrap raises a sticky status flag. Software unmasks the flags per source, and reading the status register acknowledges them.

Software sets a channel up by writing its clock control, interval and enable registers. It then writes counter control to pick the mode, release the hold and zero the counter in the same write. Each channel drives one level interrupt line. The line stays high while any unmasked flag is pending.

Top module: `tri_timer`

## Requirements
- R1: After reset every counter reads 0, counter control reads 0x01 (held), clock control, status and enable read 0, the interval reads the all-ones value of the counter width, and all interrupt lines are low.
- R2: With counter control bit 0 clear and the prescaler off (clock control bit 0 = 0), the count rises by one on every clock edge where the tick input is high, and does not change on edges where it is low.
- R3: While counter control bit 0 is set, the count and the prescaler phase keep their values whatever the tick input does.
- R4: With clock control bit 0 set and prescale value P in clock control bits 4:1, the count advances once every 2^(P+1) ticks.
- R5: A counter control write with bit 4 set zeroes the count and the prescaler phase on that write's clock edge. Bit 4 always reads back as 0, and counter control reads back only bits 1 and 0.
- R6: With counter control bit 1 set (interval mode), an advance taken while the count equals the 32-bit interval register sets the count to 0 and sets status bit 0.
- R7: In free-running mode, an advance from the all-ones count of the counter width wraps the count to 0 and sets status bit 3.
- R8: Interrupt line n is high exactly when channel n has a status flag whose bit is also set in its enable register (bits 0 and 3 are used). Writing 0 to the enable register masks every source but leaves the status flags pending.
- R9: A status read returns the flags and clears them. A flag raised on the same edge as the read stays pending.
- R10: Clock control bits 5:0 are stored and read back unchanged. Bit 5 (clock source select) has no effect on counting.
- R11: Channel n's registers sit at byte offset base + 4·n for the bases 0x00 (clock control), 0x0C (counter control), 0x18 (count, read-only), 0x24 (interval), 0x54 (status, read-only) and 0x60 (enable). Read data appears on the edge that samples the read enable and is held until the next read. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count enable shared by all channels |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 3 | Level interrupt per channel |

## Verification
The in-line assertions check four things on every cycle. A held or idle counter keeps its value. A plain advance adds exactly one. A reset request leaves both the count and the prescaler phase at zero. A status read with no new event leaves the flags clear, and any wrap event leaves its flag set on the following cycle. The directed scenarios are needed for everything that depends on software-visible sequences: the prescale ratio, the interval and overflow wrap points, the interrupt masking, the register decode per channel, and the case where a read and a new event fall on the same edge.

// File: rtl/tri_timer_pkg.sv
// Package: shared constants for the three-channel timer.
// Assumes byte addressing with channel registers interleaved at a 4-byte stride.
package tri_timer_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int CH_STRIDE  = 4;
    // group base offsets; software depends on these positions
    localparam int OFS_CLKCTL = 'h00;
    localparam int OFS_CNTCTL = 'h0C;
    localparam int OFS_COUNT  = 'h18;
    localparam int OFS_INTVL  = 'h24;
    localparam int OFS_STAT   = 'h54;
    localparam int OFS_IEN    = 'h60;
    // clock control layout
    localparam int CLK_W      = 6;
    localparam int PSV_W      = 4;
    // counter control bit positions
    localparam int CC_HOLD    = 0;
    localparam int CC_INTVL   = 1;
    localparam int CC_ZERO    = 4;
    // status / enable bit positions
    localparam int ST_INTVL   = 0;
    localparam int ST_WRAP    = 3;
endpackage

// File: rtl/tt_prescale.sv
// Module: tt_prescale
// Turns the shared tick into channel advance pulses, dividing by 2^(psv+1)
// when enabled. Assumes the phase counter is wide enough for psv = 15.
module tt_prescale
    import tri_timer_pkg::*;
#(
    parameter int PH_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             div_en_i,
    input  logic [PSV_W-1:0] psv_i,
    input  logic             zero_i,
    output logic             adv_o
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W:0]   limit;
    logic            at_limit;

    // terminal phase for the selected ratio
    always_comb begin
        limit    = ((PH_W+1)'(1) << ({1'b0, psv_i} + 5'd1)) - (PH_W+1)'(1);
        at_limit = ({1'b0, phase_q} >= limit);
        adv_o    = run_i && tick_i && !zero_i && (!div_en_i || at_limit);
    end

    // phase counter: cleared on reset request, wraps at the terminal phase
    always_ff @(posedge clk) begin
        if (!rst_n || zero_i) begin
            phase_q <= '0;
        end else if (run_i && tick_i && div_en_i) begin
            phase_q <= at_limit ? '0 : phase_q + 1'b1;
        end
    end

    // R5
    zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> phase_q == '0);

    // R3
    hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !zero_i) |=> $stable(phase_q));
endmodule

// File: rtl/tt_counter.sv
// Module: tt_counter
// Up-counter for one channel with free-running and interval wrap modes.
// Emits one-cycle pulses on interval match and on full-width overflow.
module tt_counter
    import tri_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              zero_i,
    input  logic              intvl_mode_i,
    input  logic [DATA_W-1:0] intvl_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              hit_intvl_o,
    output logic              hit_wrap_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             match;

    // wrap conditions for this advance
    always_comb begin
        match       = (DATA_W'(cnt_q) == intvl_i);
        hit_intvl_o = adv_i && intvl_mode_i && match;
        hit_wrap_o  = adv_i && !intvl_mode_i && (cnt_q == TOP);
    end

    // count register: reset request wins over an advance
    always_ff @(posedge clk) begin
        if (!rst_n || zero_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= hit_intvl_o ? '0 : cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !zero_i) |=> $stable(cnt_q));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !zero_i && cnt_q != TOP && !(intvl_mode_i && match))
        |=> cnt_q == $past(cnt_q) + 1'b1);

    // R5
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> cnt_q == '0);

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wrap_o || hit_intvl_o) && !zero_i |=> cnt_q == '0);
endmodule

// File: rtl/tt_channel.sv
// Module: tt_channel
// One timer channel: its control, interval, enable and status registers,
// plus prescaler and counter. Write and read strobes arrive pre-decoded.
module tt_channel
    import tri_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_clk_i,
    input  logic              wr_cnt_i,
    input  logic              wr_itv_i,
    input  logic              wr_ien_i,
    input  logic              rd_sts_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CLK_W-1:0]  clkctl_o,
    output logic [1:0]        cntctl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [DATA_W-1:0] intvl_o,
    output logic [1:0]        sts_o,
    output logic [1:0]        ien_o,
    output logic              irq_o
);
    logic [CLK_W-1:0]  clkctl_q;
    logic              hold_q;
    logic              mode_q;
    logic [DATA_W-1:0] intvl_q;
    logic [1:0]        ien_q;
    logic [1:0]        sts_q;
    logic              zero_req;
    logic              adv;
    logic              hit_itv;
    logic              hit_wrap;
    logic [1:0]        sts_set;

    assign zero_req = wr_cnt_i && wdata_i[CC_ZERO];
    assign sts_set  = {hit_wrap, hit_itv};

    // clock control storage (source select is kept only for readback)
    always_ff @(posedge clk) begin
        if (!rst_n)        clkctl_q <= '0;
        else if (wr_clk_i) clkctl_q <= wdata_i[CLK_W-1:0];
    end

    // counter control: hold and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            mode_q <= 1'b0;
        end else if (wr_cnt_i) begin
            hold_q <= wdata_i[CC_HOLD];
            mode_q <= wdata_i[CC_INTVL];
        end
    end

    // interval limit register
    always_ff @(posedge clk) begin
        if (!rst_n)        intvl_q <= DATA_W'({CNT_W{1'b1}});
        else if (wr_itv_i) intvl_q <= wdata_i;
    end

    // interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_q <= '0;
        else if (wr_ien_i) ien_q <= {wdata_i[ST_WRAP], wdata_i[ST_INTVL]};
    end

    // sticky status: cleared by a read, new events still land
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (rd_sts_i ? 2'b00 : sts_q) | sts_set;
    end

    tt_prescale #(.PH_W(16)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .run_i    (!hold_q),
        .div_en_i (clkctl_q[0]),
        .psv_i    (clkctl_q[PSV_W:1]),
        .zero_i   (zero_req),
        .adv_o    (adv)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (adv),
        .zero_i       (zero_req),
        .intvl_mode_i (mode_q),
        .intvl_i      (intvl_q),
        .count_o      (count_o),
        .hit_intvl_o  (hit_itv),
        .hit_wrap_o   (hit_wrap)
    );

    assign clkctl_o = clkctl_q;
    assign cntctl_o = {mode_q, hold_q};
    assign intvl_o  = intvl_q;
    assign sts_o    = sts_q;
    assign ien_o    = ien_q;
    assign irq_o    = |(sts_q & ien_q);

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts_i && sts_set == 2'b00) |=> sts_q == 2'b00);

    // R6
    itv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_itv |=> sts_q[0]);

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wrap |=> sts_q[1]);
endmodule

// File: rtl/tri_timer.sv
// Module: tri_timer
// Top level: decodes the register bus into per-channel strobes, builds
// the channels in a generate loop and returns registered read data.
// Assumes single-cycle accesses and no simultaneous read and write.
module tri_timer
    import tri_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    logic [CLK_W-1:0]  clkctl [NUM_CH];
    logic [1:0]        cntctl [NUM_CH];
    logic [CNT_W-1:0]  count  [NUM_CH];
    logic [DATA_W-1:0] intvl  [NUM_CH];
    logic [1:0]        sts    [NUM_CH];
    logic [1:0]        ien    [NUM_CH];
    logic [DATA_W-1:0] rd_mux;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(OFS_CLKCTL + CH_STRIDE*n);
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNTCTL + CH_STRIDE*n);
        localparam logic [ADDR_W-1:0] A_ITV = ADDR_W'(OFS_INTVL  + CH_STRIDE*n);
        localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STAT   + CH_STRIDE*n);
        localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFS_IEN    + CH_STRIDE*n);

        tt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .wr_clk_i (bus_we && bus_addr == A_CLK),
            .wr_cnt_i (bus_we && bus_addr == A_CNT),
            .wr_itv_i (bus_we && bus_addr == A_ITV),
            .wr_ien_i (bus_we && bus_addr == A_IEN),
            .rd_sts_i (bus_re && bus_addr == A_STS),
            .wdata_i  (bus_wdata),
            .clkctl_o (clkctl[n]),
            .cntctl_o (cntctl[n]),
            .count_o  (count[n]),
            .intvl_o  (intvl[n]),
            .sts_o    (sts[n]),
            .ien_o    (ien[n]),
            .irq_o    (irq_o[n])
        );
    end

    // read multiplexer over all channels; unmapped addresses give 0
    always_comb begin
        rd_mux = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(OFS_CLKCTL + CH_STRIDE*n)) rd_mux = DATA_W'(clkctl[n]);
            if (bus_addr == ADDR_W'(OFS_CNTCTL + CH_STRIDE*n)) rd_mux = DATA_W'(cntctl[n]);
            if (bus_addr == ADDR_W'(OFS_COUNT  + CH_STRIDE*n)) rd_mux = DATA_W'(count[n]);
            if (bus_addr == ADDR_W'(OFS_INTVL  + CH_STRIDE*n)) rd_mux = intvl[n];
            if (bus_addr == ADDR_W'(OFS_STAT   + CH_STRIDE*n))
                rd_mux = DATA_W'({sts[n][1], 2'b00, sts[n][0]});
            if (bus_addr == ADDR_W'(OFS_IEN    + CH_STRIDE*n))
                rd_mux = DATA_W'({ien[n][1], 2'b00, ien[n][0]});
        end
    end

    // read data register, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/sim_tri_timer.sv
module sim_tri_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_o;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_timer #(.NUM_CH(NCH), .CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] ra(input int base, input int ch);
        return 8'(base + 4*ch);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", 32'(irq_o), 0);
        for (int c = 0; c < NCH; c++) begin
            rd(ra('h18, c), v); check("R1 count", v, 0);
            rd(ra('h0C, c), v); check("R1 cntctl", v, 32'h1);
            rd(ra('h00, c), v); check("R1 clkctl", v, 0);
            rd(ra('h54, c), v); check("R1 status", v, 0);
            rd(ra('h60, c), v); check("R1 enable", v, 0);
            rd(ra('h24, c), v); check("R1 interval", v, 32'hFFFF);
        end
        rd(8'h70, v); check("R11 unmapped", v, 0);
    endtask

    task automatic t_free_and_hold;
        logic [31:0] v;
        wr(ra('h0C, 0), 32'h10);
        ticks(5);
        rd(ra('h18, 0), v); check("R2 five ticks", v, 5);
        repeat (3) @(negedge clk);
        rd(ra('h18, 0), v); check("R2 no tick no step", v, 5);
        rd(ra('h18, 1), v); check("R11 other channel untouched", v, 0);
        wr(ra('h0C, 0), 32'h01);
        ticks(4);
        rd(ra('h18, 0), v); check("R3 held count", v, 5);
        wr(ra('h0C, 0), 32'h10);
        rd(ra('h18, 0), v); check("R5 zeroed", v, 0);
        wr(ra('h0C, 0), 32'h01);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(ra('h00, 1), 32'h03);          // P=1 -> divide by 4
        wr(ra('h0C, 1), 32'h10);
        ticks(10);
        rd(ra('h18, 1), v); check("R4 div4 after 10", v, 2);
        ticks(2);
        rd(ra('h18, 1), v); check("R4 div4 after 12", v, 3);
        ticks(2);                          // phase now 2
        wr(ra('h0C, 1), 32'h10);
        ticks(3);
        rd(ra('h18, 1), v); check("R5 phase cleared", v, 0);
        ticks(1);
        rd(ra('h18, 1), v); check("R5 phase cleared step", v, 1);
        wr(ra('h00, 1), 32'h01);          // P=0 -> divide by 2
        wr(ra('h0C, 1), 32'h10);
        ticks(7);
        rd(ra('h18, 1), v); check("R4 div2", v, 3);
        wr(ra('h0C, 1), 32'h01);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(ra('h00, 2), 32'h2B);
        rd(ra('h00, 2), v); check("R10 clkctl readback", v, 32'h2B);
        wr(ra('h00, 2), 32'h20);          // source bit only
        wr(ra('h0C, 2), 32'h12);
        rd(ra('h0C, 2), v); check("R5 cntctl readback", v, 32'h2);
        ticks(3);
        rd(ra('h18, 2), v); check("R10 source bit no effect", v, 3);
        wr(ra('h0C, 2), 32'h01);
    endtask

    task automatic t_interval;
        logic [31:0] v;
        wr(ra('h24, 2), 3);
        wr(ra('h60, 2), 32'h1);
        wr(ra('h0C, 2), 32'h12);
        ticks(3);
        rd(ra('h18, 2), v); check("R6 at limit", v, 3);
        check("R8 no irq yet", 32'(irq_o), 0);
        ticks(1);
        rd(ra('h18, 2), v); check("R6 wrapped", v, 0);
        check("R8 irq ch2", 32'(irq_o), 32'h4);
        rd(ra('h54, 2), v); check("R6 status bit0", v, 32'h1);
        check("R9 irq dropped", 32'(irq_o), 0);
        rd(ra('h54, 2), v); check("R9 cleared", v, 0);
    endtask

    task automatic t_same_edge;
        logic [31:0] v;
        wr(ra('h24, 2), 0);
        wr(ra('h0C, 2), 32'h12);
        ticks(1);
        @(negedge clk);
        bus_addr = ra('h54, 2); bus_re = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        bus_re = 1'b0; tick_i = 1'b0;
        check("R9 read sees flag", bus_rdata, 32'h1);
        rd(ra('h54, 2), v); check("R9 new flag kept", v, 32'h1);
        rd(ra('h54, 2), v); check("R9 then clear", v, 0);
        wr(ra('h0C, 2), 32'h01);
        wr(ra('h60, 2), 0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(ra('h60, 0), 32'h8);
        wr(ra('h0C, 0), 32'h10);
        ticks(65535);
        rd(ra('h18, 0), v); check("R7 top", v, 32'hFFFF);
        rd(ra('h54, 0), v); check("R7 no flag before wrap", v, 0);
        ticks(1);
        rd(ra('h18, 0), v); check("R7 wrapped", v, 0);
        check("R8 irq ch0", 32'(irq_o), 32'h1);
        wr(ra('h60, 0), 0);
        check("R8 masked", 32'(irq_o), 0);
        rd(ra('h54, 0), v); check("R8 flag still pending", v, 32'h8);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_and_hold();
        t_prescale();
        t_readback();
        t_interval();
        t_same_edge();
        t_overflow();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule